// File: doc/BRIEF.md
# Interlocked Asynchronous Bus Read Pair

This block holds the two ends of a fully interlocked read on a shared bus with separate address, data and control lines. A requester controller takes a local request, presents the address and the read command, lets them settle for a set number of clocks and then raises its sync strobe. A responder controller in front of a small register file sees the strobe, waits a programmable response delay, drives the word onto the data lines and raises its own sync strobe. The requester captures the word and drops its strobe. The responder then drops its strobe and releases the data lines. Only after that does the requester withdraw address and command.

Each edge of the four-phase exchange waits on the previous edge from the other party. Each side passes the incoming strobe through a two-stage synchronizer before acting on it. The register file is loaded through a local write port on the responder side. A strobe that gets no answer within a bounded number of clocks ends the transfer with an error flag.

Top module: `abus_read_pair`

## Requirements
- R1: During and right after reset, bus_rd_o, bus_msyn_o, bus_ssyn_o, bus_data_oe_o, done and err are 0, and bus_addr_o and bus_data_o are 0.
- R2: On an accepted request, bus_addr_o and bus_rd_o go valid in one clock, and bus_msyn_o rises exactly SETTLE_CLKS clocks later. The requester strobe only rises while the responder strobe is low and the read command is high.
- R3: Each completed read pulses done for exactly one clock, with err 0 and rdata equal to the value most recently written to that address through the local write port (lw_en, lw_addr, lw_data). The register file resets to 0.
- R4: The responder strobe rises exactly RESP_DELAY+3 clocks after the requester strobe rises. It only rises while the requester strobe is high. bus_data_oe_o equals bus_ssyn_o at all times, and bus_data_o reads 0 whenever the enable is low.
- R5: The requester strobe falls exactly 3 clocks after the responder strobe rises, with the data captured. It only falls while the responder strobe is high or after a timeout.
- R6: The responder strobe and the data enable fall exactly 3 clocks after the requester strobe falls. The responder strobe only falls while the requester strobe is low.
- R7: The read command drops, and the address returns to 0, exactly 3 clocks after the responder strobe falls, in the same clock as done. The address does not change while the requester strobe is high.
- R8: A bus address of RF_DEPTH or higher gets no answer: the responder strobe and the data enable stay low.
- R9: If the requester strobe stays high for TIMEOUT_CLKS clocks with no answer, it drops. One clock later done and err pulse together, and rdata keeps its previous value.
- R10: A request that arrives while a transfer is in progress is ignored: it yields no extra done pulse and does not change the address on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Local read request, accepted only when idle |
| req_addr | input | ADDR_W | Address for the requested read |
| done | output | 1 | One-clock pulse at transfer end |
| rdata | output | DATA_W | Word captured by the last good read |
| err | output | 1 | Pulses with done when the transfer timed out |
| lw_en | input | 1 | Register file local write enable |
| lw_addr | input | $clog2(RF_DEPTH) | Register file local write address |
| lw_data | input | DATA_W | Register file local write data |
| bus_addr_o | output | ADDR_W | Shared address lines |
| bus_rd_o | output | 1 | Read command line |
| bus_msyn_o | output | 1 | Requester sync strobe |
| bus_ssyn_o | output | 1 | Responder sync strobe |
| bus_data_o | output | DATA_W | Resolved data lines (0 when undriven) |
| bus_data_oe_o | output | 1 | Responder data drive enable |

## Verification
The bench times every edge of the handshake against the edge from the other party that caused it. A design that skipped a synchronizer stage or miscounted the settle or response delay shifts one of these gaps by a clock. An out-of-window address must run into the timeout. A responder that decodes too loosely would answer instead, and a wrong timeout counter gives the wrong strobe length or a missing err. A second request injected mid-transfer exposes a requester that re-arms while busy: the address would move or an extra done would appear. Re-reads after overwrites, and reads of the first and last entries, catch stale or misindexed register file data.

// File: rtl/abus_pkg.sv
package abus_pkg;

  typedef enum logic [1:0] {M_IDLE, M_SETUP, M_STROBE, M_RELEASE} mst_state_e;
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ACK} slv_state_e;

  // true on the clock that finishes a wait of lim clocks
  function automatic logic last_tick(input int cnt, input int lim);
    return (cnt >= lim - 1);
  endfunction

  // responder decodes addresses below the register file depth
  function automatic logic in_window(input int addr, input int depth);
    return (addr < depth);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/abus_sync2.sv
module abus_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/abus_master.sv
module abus_master
  import abus_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int SETTLE_CLKS  = 2,
  parameter int TIMEOUT_CLKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_msyn,
  input  logic              bus_ssyn,
  input  logic [DATA_W-1:0] bus_data,
  output logic              tmo_pending
);
  localparam int CNT_W = $clog2(max3(SETTLE_CLKS, TIMEOUT_CLKS, 1) + 1);

  mst_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             ssyn_s;

  // named events for observation
  logic accept_evt, settle_evt, ack_evt, tmo_evt, release_evt;

  abus_sync2 #(.W(1)) u_ssyn_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_ssyn), .q(ssyn_s)
  );

  assign accept_evt  = (state == M_IDLE) && req;
  assign settle_evt  = (state == M_SETUP) && last_tick(int'(cnt), SETTLE_CLKS);
  assign ack_evt     = (state == M_STROBE) && ssyn_s;
  assign tmo_evt     = (state == M_STROBE) && !ssyn_s && last_tick(int'(cnt), TIMEOUT_CLKS);
  assign release_evt = (state == M_RELEASE) && !ssyn_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= M_IDLE;
      cnt         <= '0;
      bus_addr    <= '0;
      bus_rd      <= 1'b0;
      bus_msyn    <= 1'b0;
      rdata       <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
      tmo_pending <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        M_IDLE: begin
          if (accept_evt) begin
            bus_addr <= req_addr;
            bus_rd   <= 1'b1;
            cnt      <= '0;
            state    <= M_SETUP;
          end
        end
        M_SETUP: begin
          if (settle_evt) begin
            bus_msyn <= 1'b1;
            cnt      <= '0;
            state    <= M_STROBE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        M_STROBE: begin
          if (ack_evt) begin
            rdata    <= bus_data;
            bus_msyn <= 1'b0;
            state    <= M_RELEASE;
          end else if (tmo_evt) begin
            bus_msyn    <= 1'b0;
            tmo_pending <= 1'b1;
            state       <= M_RELEASE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        M_RELEASE: begin
          if (release_evt) begin
            bus_rd      <= 1'b0;
            bus_addr    <= '0;
            done        <= 1'b1;
            err         <= tmo_pending;
            tmo_pending <= 1'b0;
            state       <= M_IDLE;
          end
        end
        default: state <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/abus_slave.sv
module abus_slave
  import abus_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int RF_DEPTH   = 16,
  parameter int RESP_DELAY = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lw_en,
  input  logic [$clog2(RF_DEPTH)-1:0] lw_addr,
  input  logic [DATA_W-1:0]           lw_data,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_rd,
  input  logic                        bus_msyn,
  output logic                        bus_ssyn,
  output logic [DATA_W-1:0]           data_drv,
  output logic                        data_oe
);
  localparam int RF_AW = $clog2(RF_DEPTH);
  localparam int CNT_W = $clog2(max3(RESP_DELAY, 1, 1) + 1);

  logic [DATA_W-1:0] rf [RF_DEPTH];
  slv_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic              msyn_s;
  logic              select, start_evt, answer_evt, abort_evt, drop_evt;

  // one register per entry, loaded through the local port
  for (genvar g = 0; g < RF_DEPTH; g++) begin : g_rf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  rf[g] <= '0;
      else if (lw_en && (lw_addr == RF_AW'(g)))    rf[g] <= lw_data;
    end
  end

  abus_sync2 #(.W(1)) u_msyn_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_msyn), .q(msyn_s)
  );

  assign select     = bus_rd && in_window(int'(bus_addr), RF_DEPTH);
  assign start_evt  = (state == S_IDLE) && msyn_s && select;
  assign abort_evt  = (state == S_WAIT) && !msyn_s;
  assign answer_evt = (state == S_WAIT) && msyn_s && last_tick(int'(cnt), RESP_DELAY);
  assign drop_evt   = (state == S_ACK) && !msyn_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      bus_ssyn <= 1'b0;
      data_oe  <= 1'b0;
      data_drv <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start_evt) begin
            data_drv <= rf[bus_addr[RF_AW-1:0]];
            cnt      <= '0;
            state    <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (abort_evt) begin
            state <= S_IDLE;
          end else if (answer_evt) begin
            bus_ssyn <= 1'b1;
            data_oe  <= 1'b1;
            state    <= S_ACK;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ACK: begin
          if (drop_evt) begin
            bus_ssyn <= 1'b0;
            data_oe  <= 1'b0;
            state    <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/abus_read_pair.sv
module abus_read_pair #(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int RF_DEPTH     = 16,
  parameter int SETTLE_CLKS  = 2,
  parameter int RESP_DELAY   = 3,
  parameter int TIMEOUT_CLKS = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req,
  input  logic [ADDR_W-1:0]           req_addr,
  output logic                        done,
  output logic [DATA_W-1:0]           rdata,
  output logic                        err,
  input  logic                        lw_en,
  input  logic [$clog2(RF_DEPTH)-1:0] lw_addr,
  input  logic [DATA_W-1:0]           lw_data,
  output logic [ADDR_W-1:0]           bus_addr_o,
  output logic                        bus_rd_o,
  output logic                        bus_msyn_o,
  output logic                        bus_ssyn_o,
  output logic [DATA_W-1:0]           bus_data_o,
  output logic                        bus_data_oe_o
);
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_rd, bus_msyn, bus_ssyn, data_oe, m_tmo;
  logic [DATA_W-1:0] data_drv, bus_data;

  // shared data lines: only the responder drives, else released (reads 0)
  assign bus_data = data_oe ? data_drv : '0;

  abus_master #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SETTLE_CLKS(SETTLE_CLKS), .TIMEOUT_CLKS(TIMEOUT_CLKS)
  ) u_master (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
    .done(done), .rdata(rdata), .err(err),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_msyn(bus_msyn),
    .bus_ssyn(bus_ssyn), .bus_data(bus_data), .tmo_pending(m_tmo)
  );

  abus_slave #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .RF_DEPTH(RF_DEPTH), .RESP_DELAY(RESP_DELAY)
  ) u_slave (
    .clk(clk), .rst_n(rst_n),
    .lw_en(lw_en), .lw_addr(lw_addr), .lw_data(lw_data),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_msyn(bus_msyn),
    .bus_ssyn(bus_ssyn), .data_drv(data_drv), .data_oe(data_oe)
  );

  assign bus_addr_o    = bus_addr;
  assign bus_rd_o      = bus_rd;
  assign bus_msyn_o    = bus_msyn;
  assign bus_ssyn_o    = bus_ssyn;
  assign bus_data_o    = bus_data;
  assign bus_data_oe_o = data_oe;
endmodule

// File: rtl/abus_read_checker.sv
module abus_read_checker #(
  parameter int ADDR_W   = 8,
  parameter int RF_DEPTH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd,
  input logic              msyn,
  input logic              ssyn,
  input logic              oe,
  input logic              done,
  input logic              err,
  input logic              tmo
);
  assert_msyn_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msyn) |-> (!ssyn && rd));

  assert_ack_in_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!msyn && !ssyn && !oe));

  assert_ssyn_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssyn) |-> msyn);

  assert_drive_needs_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> rd);

  assert_msyn_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msyn) |-> (ssyn || tmo));

  assert_ssyn_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ssyn) |-> !msyn);

  assert_rd_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd) |-> (!msyn && !ssyn));

  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msyn && $past(msyn)) |-> $stable(addr));

  assert_no_ack_out_of_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ssyn |-> (int'(addr) < RF_DEPTH));

  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

bind abus_read_pair abus_read_checker #(.ADDR_W(ADDR_W), .RF_DEPTH(RF_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(bus_addr_o), .rd(bus_rd_o),
  .msyn(bus_msyn_o), .ssyn(bus_ssyn_o), .oe(bus_data_oe_o),
  .done(done), .err(err), .tmo(m_tmo)
);

// File: tb/abus_read_pair_test.sv
module abus_read_pair_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, DW = 8, DEPTH = 16, SETTLE = 2, DELAY = 3, TMO = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, lw_en = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    lw_addr = '0;
  logic [DW-1:0] lw_data = '0;
  logic done, err, rd, msyn, ssyn, oe;
  logic [DW-1:0] rdata, bdata;
  logic [AW-1:0] baddr;

  int checks = 0, errors = 0, cyc = 0, dones = 0, oe_bad = 0;
  bit finished = 0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] last_good = '0;
  logic [DW:0]   expq [$];   // {err, data}

  abus_read_pair #(
    .ADDR_W(AW), .DATA_W(DW), .RF_DEPTH(DEPTH),
    .SETTLE_CLKS(SETTLE), .RESP_DELAY(DELAY), .TIMEOUT_CLKS(TMO)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
    .done(done), .rdata(rdata), .err(err),
    .lw_en(lw_en), .lw_addr(lw_addr), .lw_data(lw_data),
    .bus_addr_o(baddr), .bus_rd_o(rd), .bus_msyn_o(msyn),
    .bus_ssyn_o(ssyn), .bus_data_o(bdata), .bus_data_oe_o(oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // R4: enable tracks the responder strobe; released lines read 0
  always @(negedge clk) if (rst_n && ((oe != ssyn) || (!oe && bdata != '0))) oe_bad++;

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      dones++;
      if (expq.size() == 0) begin
        check(0, "R10 unexpected done", 1, 0);
      end else begin
        logic [DW:0] e;
        e = expq.pop_front();
        check(err == e[DW], "R9 err flag", int'(err), int'(e[DW]));
        check(rdata == e[DW-1:0], "R3 read data", int'(rdata), int'(e[DW-1:0]));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "watchdog", cyc, 150000);
    finish_run();
  end

  task automatic local_write(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    lw_en = 1'b1; lw_addr = 4'(a); lw_data = d;
    @(negedge clk);
    lw_en = 1'b0;
    model[a] = d;
  endtask

  // driver: push expectation, issue request, time each handshake edge
  task automatic run_read(input int a, input bit poke_busy);
    int n = 0, n_rd = -1, n_ms = -1, n_ss = -1, n_msf = -1, n_ssf = -1, n_rdf = -1, n_done = -1;
    bit timed_out = (a >= DEPTH);
    bit saw_ssyn = 0;
    int d0 = dones;
    logic [AW-1:0] held = '0;
    expq.push_back(timed_out ? {1'b1, last_good} : {1'b0, model[a]});
    if (!timed_out) last_good = model[a];
    @(negedge clk);
    req = 1'b1; req_addr = AW'(a);
    @(negedge clk);
    req = 1'b0;
    while (n_done < 0 && n < 400) begin
      n++;
      if (rd && n_rd < 0) begin n_rd = n; held = baddr; end
      if (msyn && n_ms < 0) n_ms = n;
      if (ssyn) saw_ssyn = 1;
      if (ssyn && n_ss < 0) n_ss = n;
      if (!msyn && n_ms > 0 && n_msf < 0) n_msf = n;
      if (!ssyn && n_ss > 0 && n_ssf < 0) n_ssf = n;
      if (!rd && n_rd > 0 && n_rdf < 0) n_rdf = n;
      if (done) n_done = n;
      if (poke_busy && n == n_ms + 1 && n_ms > 0) begin
        req = 1'b1; req_addr = AW'(a ^ 1);
      end else begin
        req = 1'b0;
      end
      if (msyn && baddr != held) check(0, "R10 R7 address moved", int'(baddr), int'(held));
      @(negedge clk);
    end
    req = 1'b0;
    n_rd = n_rd; // recorded at the first negedge after the accepting edge
    check(n_rd == 0 || n_rd == 1, "R2 command presented", n_rd, 1);
    check(held == AW'(a), "R2 address on bus", int'(held), a);
    check(n_ms - n_rd == SETTLE, "R2 settle gap", n_ms - n_rd, SETTLE);
    if (timed_out) begin
      check(!saw_ssyn, "R8 no answer out of window", int'(saw_ssyn), 0);
      check(n_msf - n_ms == TMO, "R9 strobe length on timeout", n_msf - n_ms, TMO);
      check(n_done - n_msf == 1, "R9 done after timeout", n_done - n_msf, 1);
    end else begin
      check(n_ss - n_ms == DELAY + 3, "R4 response gap", n_ss - n_ms, DELAY + 3);
      check(n_msf - n_ss == 3, "R5 capture and drop", n_msf - n_ss, 3);
      check(n_ssf - n_msf == 3, "R6 responder release", n_ssf - n_msf, 3);
      check(n_rdf - n_ssf == 3, "R7 command removal", n_rdf - n_ssf, 3);
    end
    check(n_rdf == n_done, "R7 command drops with done", n_rdf, n_done);
    repeat (12) begin
      @(negedge clk);
      check(!done, "R3 R10 single done pulse", int'(done), 0);
    end
    check(dones - d0 == 1, "R10 one done per request", dones - d0, 1);
    check(baddr == '0 && !rd, "R7 address released", int'(baddr), 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!rd && !msyn && !ssyn && !oe && !done && !err, "R1 controls in reset",
          int'({rd, msyn, ssyn, oe, done, err}), 0);
    check(baddr == '0 && bdata == '0, "R1 lines in reset", int'(baddr) + int'(bdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rd && !msyn && !ssyn && !done, "R1 idle after reset",
          int'({rd, msyn, ssyn, done}), 0);

    run_read(5, 0);                                 // R3: reset value 0
    for (int i = 0; i < DEPTH; i++) local_write(i, DW'((i * 37 + 11) ^ 8'h5A));
    run_read(3, 0);
    run_read(0, 0);                                 // first entry
    run_read(DEPTH - 1, 0);                         // last entry
    local_write(3, 8'hC3);
    run_read(3, 0);                                 // R3: overwrite seen
    run_read(9, 1);                                 // R10: busy request ignored
    run_read(DEPTH, 0);                             // R8/R9: just past window
    run_read(200, 0);                               // R8/R9: far out
    run_read(7, 0);                                 // recovery after timeout
    check(oe_bad == 0, "R4 data enable tracks strobe", oe_bad, 0);
    check(expq.size() == 0, "R3 scoreboard drained", expq.size(), 0);
    finish_run();
  end
endmodule